// File: doc/BRIEF.md
# Synchronous Serial Slave Receiver

This block receives asynchronous-format characters over a two-wire synchronous link. The far end drives both the serial clock and the data line. The receiver runs on its own system clock. It brings both wires into that clock domain through a shared two-stage synchronizer and detects serial-clock edges from the synchronized copy. On each edge of the configured sampling direction, it takes one data bit.

The frame format is set by configuration inputs:
- the character length, from 5 to 9 bits;
- the parity mode: none, even or odd;
- the number of stop bits: one or two.

For each completed frame the block outputs the character right-aligned in a 9-bit word. It raises a one-cycle valid strobe, with parity-error and frame-error flags that are valid in the same cycle. The serial clock must run below one quarter of the system clock frequency. The data line must be stable around each sampling edge. Configuration may change only while the line is idle.

Top module: `sync_slave_rx`

## Requirements
- R1: While idle, the receiver starts a frame only when it samples a low data level on a sampling edge. High samples leave it idle and produce no output.
- R2: With `cfgPolarity` = 0, data is sampled on falling serial-clock edges. With `cfgPolarity` = 1, it is sampled on rising edges. Levels present only around the other edge are never taken.
- R3: After the start bit, `cfgDataBits` (5 to 9) data bits are received least significant bit first.
- R4: The character appears on `rxData` bits [n-1:0], with every bit at position n or higher equal to zero.
- R5: `cfgParity` encoding: 0 or 1 means no parity bit, 2 means even parity, 3 means odd parity. When parity is enabled, one parity bit follows the data bits.
- R6: `rxParityErr` is 1 together with `rxValid` when parity is enabled and the count of ones over the data bits and the parity bit is odd (even mode) or even (odd mode).
- R7: `rxFrameErr` is 1 together with `rxValid` when the first stop bit is sampled low.
- R8: With `cfgTwoStop` = 1, the second stop bit is consumed without any check. A low level there raises no error and does not start a new frame.
- R9: Each received frame produces exactly one `rxValid` pulse, one system clock long. Both error flags are 0 whenever `rxValid` is 0.
- R10: After reset, `rxValid`, `rxData`, `rxParityErr` and `rxFrameErr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| serClkIn | input | 1 | Serial clock driven by the remote end |
| serDataIn | input | 1 | Serial data line, idles high |
| cfgPolarity | input | 1 | Sampling edge select: 0 falling, 1 rising |
| cfgDataBits | input | 4 | Character length, 5 to 9 |
| cfgParity | input | 2 | Parity mode: 0/1 none, 2 even, 3 odd |
| cfgTwoStop | input | 1 | 1 selects two stop bits |
| rxData | output | 9 | Received character, right-aligned |
| rxValid | output | 1 | One-cycle strobe for a completed frame |
| rxParityErr | output | 1 | Parity mismatch, valid with rxValid |
| rxFrameErr | output | 1 | First stop bit low, valid with rxValid |

## Verification
The hardest cases to reach are a low level on the data line that the receiver must not act on. One is a low second stop bit. The other is a low pulse held only across the non-sampling clock edge. The stimulus creates both on purpose. It then lets the line idle and sends an ordinary frame. Any spurious start would then show up as an extra strobe or a corrupted character. The random frames mix every length, parity mode, stop count and polarity, with corrupted parity and low stop bits injected, so that all flag combinations are exercised.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA,
    ST_PARITY,
    ST_STOP1,
    ST_STOP2
  } rxState_t;

  typedef struct packed {
    logic startFrame;
    logic shiftBit;
    logic takeParity;
    logic emit;
  } rxCtrl_t;
endpackage

// File: rtl/srx_datapath.sv
module srx_datapath
  import srx_pkg::*;
#(
  parameter int DATA_MAX    = 9,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(DATA_MAX + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                serClkIn,
  input  logic                serDataIn,
  input  logic                cfgPolarity,
  input  logic [CNT_W-1:0]    cfgDataBits,
  input  logic [1:0]          cfgParity,
  input  rxCtrl_t             ctrl,
  output logic                sampleEdge,
  output logic                sampleBit,
  output logic [DATA_MAX-1:0] rxData,
  output logic                rxValid,
  output logic                rxParityErr,
  output logic                rxFrameErr
);
  logic [SYNC_STAGES-1:0] clkSync, dataSync;
  logic clkPrev, clkRise, clkFall;
  logic [DATA_MAX-1:0] shiftReg;
  logic parAcc;
  logic [CNT_W-1:0] alignShift;

  // clock and data share the same synchronizer depth so they stay aligned
  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkSync  <= '0;
      dataSync <= '1;
      clkPrev  <= 1'b0;
    end else begin
      clkSync  <= {clkSync[SYNC_STAGES-2:0], serClkIn};
      dataSync <= {dataSync[SYNC_STAGES-2:0], serDataIn};
      clkPrev  <= clkSync[SYNC_STAGES-1];
    end
  end

  assign clkRise    = clkSync[SYNC_STAGES-1] & ~clkPrev;
  assign clkFall    = ~clkSync[SYNC_STAGES-1] & clkPrev;
  assign sampleEdge = cfgPolarity ? clkRise : clkFall;
  assign sampleBit  = dataSync[SYNC_STAGES-1];
  assign alignShift = CNT_W'(DATA_MAX) - cfgDataBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      parAcc   <= 1'b0;
    end else if (ctrl.startFrame) begin
      shiftReg <= '0;
      parAcc   <= 1'b0;
    end else if (ctrl.shiftBit) begin
      shiftReg <= {sampleBit, shiftReg[DATA_MAX-1:1]};
      parAcc   <= parAcc ^ sampleBit;
    end else if (ctrl.takeParity) begin
      parAcc   <= parAcc ^ sampleBit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData      <= '0;
      rxValid     <= 1'b0;
      rxParityErr <= 1'b0;
      rxFrameErr  <= 1'b0;
    end else if (ctrl.emit) begin
      rxData      <= shiftReg >> alignShift;
      rxValid     <= 1'b1;
      rxParityErr <= cfgParity[1] & (parAcc ^ cfgParity[0]);
      rxFrameErr  <= ~sampleBit;
    end else begin
      rxValid     <= 1'b0;
      rxParityErr <= 1'b0;
      rxFrameErr  <= 1'b0;
    end
  end

  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);
  p_flags_with_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rxParityErr || rxFrameErr) |-> rxValid);
  p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> ((rxData >> cfgDataBits) == '0));
endmodule

// File: rtl/srx_control.sv
module srx_control
  import srx_pkg::*;
#(
  parameter int DATA_MAX = 9,
  localparam int CNT_W   = $clog2(DATA_MAX + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleEdge,
  input  logic             sampleBit,
  input  logic [CNT_W-1:0] cfgDataBits,
  input  logic [1:0]       cfgParity,
  input  logic             cfgTwoStop,
  output rxCtrl_t          ctrl
);
  rxState_t state, stateNext;
  logic [CNT_W-1:0] bitCnt, bitCntNext;

  always_comb begin
    ctrl       = '0;
    stateNext  = state;
    bitCntNext = bitCnt;
    if (sampleEdge) begin
      case (state)
        ST_IDLE: if (!sampleBit) begin
          ctrl.startFrame = 1'b1;
          stateNext       = ST_DATA;
          bitCntNext      = '0;
        end
        ST_DATA: begin
          ctrl.shiftBit = 1'b1;
          if (bitCnt == cfgDataBits - CNT_W'(1))
            stateNext = cfgParity[1] ? ST_PARITY : ST_STOP1;
          else
            bitCntNext = bitCnt + CNT_W'(1);
        end
        ST_PARITY: begin
          ctrl.takeParity = 1'b1;
          stateNext       = ST_STOP1;
        end
        ST_STOP1: begin
          ctrl.emit = 1'b1;
          stateNext = cfgTwoStop ? ST_STOP2 : ST_IDLE;
        end
        ST_STOP2: stateNext = ST_IDLE;
        default:  stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      state  <= stateNext;
      bitCnt <= bitCntNext;
    end
  end

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !(sampleEdge && !sampleBit)) |=> state == ST_IDLE);
  p_parity_state_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PARITY) |-> cfgParity[1]);
  p_stop2_exit_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STOP2 && sampleEdge) |=> state == ST_IDLE);
endmodule

// File: rtl/sync_slave_rx.sv
module sync_slave_rx
  import srx_pkg::*;
#(
  parameter int DATA_MAX    = 9,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(DATA_MAX + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                serClkIn,
  input  logic                serDataIn,
  input  logic                cfgPolarity,
  input  logic [CNT_W-1:0]    cfgDataBits,
  input  logic [1:0]          cfgParity,
  input  logic                cfgTwoStop,
  output logic [DATA_MAX-1:0] rxData,
  output logic                rxValid,
  output logic                rxParityErr,
  output logic                rxFrameErr
);
  rxCtrl_t ctrl;
  logic sampleEdge, sampleBit;

  srx_control #(.DATA_MAX(DATA_MAX)) uControl (
    .clk(clk), .rstN(rstN), .sampleEdge(sampleEdge), .sampleBit(sampleBit),
    .cfgDataBits(cfgDataBits), .cfgParity(cfgParity), .cfgTwoStop(cfgTwoStop),
    .ctrl(ctrl)
  );

  srx_datapath #(.DATA_MAX(DATA_MAX), .SYNC_STAGES(SYNC_STAGES)) uDatapath (
    .clk(clk), .rstN(rstN), .serClkIn(serClkIn), .serDataIn(serDataIn),
    .cfgPolarity(cfgPolarity), .cfgDataBits(cfgDataBits), .cfgParity(cfgParity),
    .ctrl(ctrl), .sampleEdge(sampleEdge), .sampleBit(sampleBit),
    .rxData(rxData), .rxValid(rxValid), .rxParityErr(rxParityErr),
    .rxFrameErr(rxFrameErr)
  );
endmodule

// File: tb/sync_slave_rx_test.sv
module sync_slave_rx_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClkIn = 1'b0;
  logic serDataIn = 1'b1;
  logic cfgPolarity = 1'b0;
  logic [3:0] cfgDataBits = 4'd8;
  logic [1:0] cfgParity = 2'd0;
  logic cfgTwoStop = 1'b0;
  logic [8:0] rxData;
  logic rxValid, rxParityErr, rxFrameErr;

  int nChecks = 0;
  int nErrors = 0;
  int pushIdx = 0;
  int popIdx = 0;
  bit finished = 1'b0;
  logic [8:0] expData [0:255];
  logic expPe [0:255];
  logic expFe [0:255];

  always #5 clk = ~clk;

  sync_slave_rx uut (
    .clk(clk), .rstN(rstN), .serClkIn(serClkIn), .serDataIn(serDataIn),
    .cfgPolarity(cfgPolarity), .cfgDataBits(cfgDataBits), .cfgParity(cfgParity),
    .cfgTwoStop(cfgTwoStop), .rxData(rxData), .rxValid(rxValid),
    .rxParityErr(rxParityErr), .rxFrameErr(rxFrameErr)
  );

  function automatic logic [8:0] maskData(logic [8:0] d, int n);
    return d & 9'((1 << n) - 1);
  endfunction

  function automatic logic goodParity(logic [8:0] d, logic odd);
    return (^d) ^ odd;
  endfunction

  // monitor: every strobe is matched against the next expected frame (R9)
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (rxValid) begin
        if (popIdx >= pushIdx) begin
          nChecks++; nErrors++;
          $display("FAIL R1 unexpected strobe: actual data %h, expected no frame", rxData);
        end else begin
          nChecks++;
          if (rxData !== expData[popIdx]) begin
            nErrors++;
            $display("FAIL R3/R4 frame %0d data: actual %h expected %h", popIdx, rxData, expData[popIdx]);
          end
          nChecks++;
          if (rxParityErr !== expPe[popIdx]) begin
            nErrors++;
            $display("FAIL R6 frame %0d parity flag: actual %b expected %b", popIdx, rxParityErr, expPe[popIdx]);
          end
          nChecks++;
          if (rxFrameErr !== expFe[popIdx]) begin
            nErrors++;
            $display("FAIL R7 frame %0d frame flag: actual %b expected %b", popIdx, rxFrameErr, expFe[popIdx]);
          end
          popIdx++;
        end
      end else if (rxParityErr || rxFrameErr) begin
        nChecks++; nErrors++;
        $display("FAIL R9 flag without strobe: actual pe=%b fe=%b expected 0 0", rxParityErr, rxFrameErr);
      end
    end
  end

  // change level is ~polarity, sample level is polarity (R2)
  task automatic sendBit(input logic b);
    @(negedge clk);
    serClkIn = ~cfgPolarity;
    serDataIn = b;
    repeat (4) @(negedge clk);
    serClkIn = cfgPolarity;
    repeat (4) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [8:0] d, input logic corruptPar,
                           input logic stop1, input logic stop2);
    int n;
    n = int'(cfgDataBits);
    expData[pushIdx] = maskData(d, n);
    expPe[pushIdx] = cfgParity[1] & corruptPar;
    expFe[pushIdx] = ~stop1;
    pushIdx++;
    sendBit(1'b0);
    for (int i = 0; i < n; i++) sendBit(d[i]);
    if (cfgParity[1]) sendBit(goodParity(maskData(d, n), cfgParity[0]) ^ corruptPar);
    sendBit(stop1);
    if (cfgTwoStop) sendBit(stop2);
  endtask

  task automatic setCfg(input logic pol, input logic [3:0] nb, input logic [1:0] par, input logic two);
    @(negedge clk);
    serDataIn = 1'b1;
    cfgPolarity = pol;
    serClkIn = pol;
    cfgDataBits = nb;
    cfgParity = par;
    cfgTwoStop = two;
    sendBit(1'b1);
    sendBit(1'b1);
  endtask

  task automatic checkCount(input string tag);
    repeat (12) @(negedge clk);
    nChecks++;
    if (popIdx != pushIdx) begin
      nErrors++;
      $display("FAIL %s frame count: actual %0d expected %0d", tag, popIdx, pushIdx);
    end
  endtask

  initial begin
    int seed;
    seed = $urandom(1234);
    repeat (4) @(negedge clk);
    // R10 reset state
    nChecks++;
    if (rxValid !== 1'b0 || rxData !== 9'd0 || rxParityErr !== 1'b0 || rxFrameErr !== 1'b0) begin
      nErrors++;
      $display("FAIL R10 reset: actual v=%b d=%h pe=%b fe=%b expected all zero",
               rxValid, rxData, rxParityErr, rxFrameErr);
    end
    rstN = 1'b1;

    // R3 nine bits, odd parity
    setCfg(1'b0, 4'd9, 2'd3, 1'b0);
    sendFrame(9'h1A5, 1'b0, 1'b1, 1'b1);
    // R4 five bits, even parity, upper bits of stimulus set
    setCfg(1'b1, 4'd5, 2'd2, 1'b0);
    sendFrame(9'h1F3, 1'b0, 1'b1, 1'b1);
    // R6 parity corrupted, R7 low stop bit
    sendFrame(9'h00A, 1'b1, 1'b1, 1'b1);
    sendFrame(9'h015, 1'b0, 1'b0, 1'b1);
    checkCount("R1");

    // R8 low second stop bit, then idle, then a normal frame
    setCfg(1'b0, 4'd8, 2'd0, 1'b1);
    sendFrame(9'h0C3, 1'b0, 1'b1, 1'b0);
    sendBit(1'b1);
    sendBit(1'b1);
    sendFrame(9'h05A, 1'b0, 1'b1, 1'b1);
    checkCount("R8");

    // R2 low level held only across the non-sampling (falling) edge with polarity 1
    setCfg(1'b1, 4'd7, 2'd0, 1'b0);
    @(negedge clk);
    serDataIn = 1'b0;
    repeat (2) @(negedge clk);
    serClkIn = 1'b0;
    repeat (4) @(negedge clk);
    serDataIn = 1'b1;
    repeat (4) @(negedge clk);
    serClkIn = 1'b1;
    repeat (4) @(negedge clk);
    checkCount("R2");
    sendFrame(9'h03C, 1'b0, 1'b1, 1'b1);
    checkCount("R2");

    // random mix: R3 R5 R6 R7 R8 under both polarities (R2)
    for (int f = 0; f < 60; f++) begin
      if (f % 4 == 0)
        setCfg(1'($urandom_range(0, 1)), 4'($urandom_range(5, 9)),
               2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
      sendFrame(9'($urandom_range(0, 511)), ($urandom_range(0, 3) == 0),
                ($urandom_range(0, 4) != 0), 1'($urandom_range(0, 1)));
      repeat ($urandom_range(0, 2)) sendBit(1'b1);
    end
    checkCount("R9");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++; nErrors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end
endmodule